// File: doc/BRIEF.md
# Fractional-N Divide Modulus Sequencer

This block chooses, once per completed feedback division, the whole-number modulus that a programmable divider has to count next. Over many divisions the average of these moduli equals N + F/2^28. N is an 8-bit unsigned integer part and F is a 28-bit unsigned fraction, so the frequency step is the comparison frequency divided by 2^28. For example, a ratio of 86.05625 is written as N = 86 (binary 0101_0110) and F = 15,099,494. The dither comes from a cascade of three first-order accumulators whose carries are combined with noise shaping. In each division this adds an offset between -3 and +4 to N.

A small counting divider is part of the block. It counts the current modulus in clock cycles, pulses once at the end of each division, and that pulse moves the sequencer on. A load strobe captures new N, F and integer-mode settings into holding registers at any time. They are used only when the division in progress ends. In integer mode dithering stops and the divider uses N alone. The modulus is always held between 35 and 251, and an out-of-range N sets a flag.

Top module: `fracn_divseq`

## Requirements
- R1: After reset, mod_valid is 0, mod_value is 177, mod_offset is 0, n_range_err is 0 and the fraction accumulators are cleared.
- R2: With cfg_int = 0 and N in 39..247, the sum of the moduli of K consecutive divisions is within ±4 of K·N + floor(K·F/2^28), where N is cfg_n and F is cfg_frac, both read as unsigned binary.
- R3: With cfg_int = 0, mod_offset is a 4-bit two's-complement value in -3..+4, and for N in 39..247 mod_value equals N + mod_offset.
- R4: With cfg_int = 1, every modulus equals N and mod_offset is 0, whatever the value of F.
- R5: mod_value never leaves 35..251. When N + offset would go below 35 the modulus is 35, and when it would go above 251 the modulus is 251.
- R6: A load with cfg_n below 35 or above 251 sets n_range_err, and a load with a legal cfg_n clears it. An illegal N is used as the nearest bound. Both 35 and 251 are legal.
- R7: cfg_load only updates the holding registers. mod_value and mod_offset change only at the clock edge where div_pulse is high, so the division in progress keeps its length.
- R8: div_pulse is high for a single cycle at the end of each division. The number of cycles between two pulses equals the mod_value seen at the second pulse.
- R9: mod_valid rises at the first division boundary after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Captures cfg_n, cfg_frac and cfg_int into the holding registers |
| cfg_int | input | 1 | Integer mode: freezes dithering |
| cfg_n | input | 8 | Integer part N, unsigned |
| cfg_frac | input | 28 | Fraction F, unsigned, in units of 2^-28 |
| mod_value | output | 8 | Modulus of the current division |
| mod_offset | output | 4 | Signed dither offset applied to N |
| mod_valid | output | 1 | High once a programmed modulus has been issued |
| n_range_err | output | 1 | Last loaded N was outside 35..251 |
| div_pulse | output | 1 | One-cycle pulse at the end of each division |

## Verification
Some properties are checked by assertions on every cycle. The modulus stays inside its bounds, the offset stays within its span, the outputs hold still between boundaries, pulses never come back to back, valid follows the first boundary, and the range flag follows each load. Other properties need whole scenarios in the bench. These are the long-run average against N + F/2^28, the exact division length, integer mode ignoring F, and a load that arrives mid-division taking effect only at the next boundary.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

   function automatic int fracn_clip(input int v, input int lo, input int hi);
      int r;
      r = v;
      if (r < lo) r = lo;
      if (r > hi) r = hi;
      return r;
   endfunction

   // Largest positive offset of a noise-shaped cascade of the given order
   function automatic int fracn_off_max(input int order);
      return 1 << (order - 1);
   endfunction

   // Most negative offset of a noise-shaped cascade of the given order
   function automatic int fracn_off_min(input int order);
      return 1 - (1 << (order - 1));
   endfunction

endpackage

// File: rtl/fracn_mash_stage.sv
module fracn_mash_stage #(
   parameter int FW = 28,
   parameter int OW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic                 freeze,
   input  logic [FW-1:0]        din,
   input  logic signed [OW-1:0] inner,
   output logic [FW-1:0]        sum,
   output logic signed [OW-1:0] shaped
);

   logic [FW-1:0]        acc_q;
   logic signed [OW-1:0] inner_q;
   logic [FW:0]          total;

   // Accumulate; the bit above the fraction is this stage's carry
   assign total  = {1'b0, acc_q} + {1'b0, din};
   assign sum    = total[FW-1:0];
   // Carry plus first difference of the later stages' shaped output
   assign shaped = $signed({{(OW-1){1'b0}}, total[FW]}) + inner - inner_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         inner_q <= '0;
      end else if (step && !freeze) begin
         acc_q   <= sum;
         inner_q <= inner;
      end
   end

endmodule

// File: rtl/fracn_mod_sel.sv
module fracn_mod_sel
   import fracn_pkg::*;
#(
   parameter int NW      = 8,
   parameter int FW      = 28,
   parameter int OFW     = 4,
   parameter int N_MIN   = 35,
   parameter int N_MAX   = 251,
   parameter int N_RESET = 177
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_load,
   input  logic                  cfg_int,
   input  logic [NW-1:0]         cfg_n,
   input  logic [FW-1:0]         cfg_frac,
   input  logic                  step,
   input  logic signed [OFW-1:0] offset,
   output logic [FW-1:0]         sh_frac,
   output logic                  sh_int,
   output logic [NW-1:0]         mod_value,
   output logic signed [OFW-1:0] mod_offset,
   output logic                  mod_valid,
   output logic                  n_range_err
);

   logic [NW-1:0] sh_n;
   int            n_eff;
   int            off_eff;
   int            m_next;

   // Holding registers: written on load, consumed only at a boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_n        <= NW'(N_RESET);
         sh_frac     <= '0;
         sh_int      <= 1'b0;
         n_range_err <= 1'b0;
      end else if (cfg_load) begin
         sh_n        <= cfg_n;
         sh_frac     <= cfg_frac;
         sh_int      <= cfg_int;
         n_range_err <= (int'(cfg_n) < N_MIN) || (int'(cfg_n) > N_MAX);
      end
   end

   always_comb begin
      n_eff   = fracn_clip(int'(sh_n), N_MIN, N_MAX);
      off_eff = sh_int ? 0 : int'(offset);
      m_next  = fracn_clip(n_eff + off_eff, N_MIN, N_MAX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mod_value  <= NW'(N_RESET);
         mod_offset <= '0;
         mod_valid  <= 1'b0;
      end else if (step) begin
         mod_value  <= NW'(m_next);
         mod_offset <= OFW'(off_eff);
         mod_valid  <= 1'b1;
      end
   end

endmodule

// File: rtl/fracn_cnt_div.sv
module fracn_cnt_div #(
   parameter int NW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NW-1:0] modulus,
   output logic          pulse
);

   logic [NW-1:0] cnt_q;

   // Last count of the division: the modulus is consumed here
   assign pulse = (cnt_q == (modulus - NW'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (pulse) cnt_q <= '0;
      else            cnt_q <= cnt_q + NW'(1);
   end

endmodule

// File: rtl/fracn_divseq.sv
module fracn_divseq #(
   parameter int NW      = 8,
   parameter int FW      = 28,
   parameter int ORDER   = 3,
   parameter int N_MIN   = 35,
   parameter int N_MAX   = 251,
   parameter int N_RESET = 177
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_load,
   input  logic                     cfg_int,
   input  logic [NW-1:0]            cfg_n,
   input  logic [FW-1:0]            cfg_frac,
   output logic [NW-1:0]            mod_value,
   output logic signed [ORDER:0]    mod_offset,
   output logic                     mod_valid,
   output logic                     n_range_err,
   output logic                     div_pulse
);

   localparam int OFW = ORDER + 1;

   // Elaboration-time parameter checks
   if (ORDER < 1 || ORDER > 3) begin : g_bad_order
      $error("fracn_divseq: ORDER must be 1..3");
   end
   if (FW < 2 || FW > 62) begin : g_bad_fw
      $error("fracn_divseq: FW out of supported range");
   end
   if (N_MIN < 2 || N_MIN > N_MAX || N_MAX >= (1 << NW)) begin : g_bad_bounds
      $error("fracn_divseq: modulus bounds do not fit");
   end
   if (N_RESET < N_MIN || N_RESET > N_MAX) begin : g_bad_reset
      $error("fracn_divseq: reset modulus out of bounds");
   end

   logic [FW-1:0]        sh_frac;
   logic                 sh_int;
   logic [FW-1:0]        stg_din [ORDER];
   logic [FW-1:0]        stg_sum [ORDER];
   logic signed [OFW-1:0] stg_shp [ORDER+1];

   assign stg_shp[ORDER] = '0;

   // Cascade of accumulators; each feeds its residue to the next
   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign stg_din[k] = sh_frac;
      end else begin : g_next
         assign stg_din[k] = stg_sum[k-1];
      end
      fracn_mash_stage #(
         .FW (FW),
         .OW (OFW)
      ) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (div_pulse),
         .freeze (sh_int),
         .din    (stg_din[k]),
         .inner  (stg_shp[k+1]),
         .sum    (stg_sum[k]),
         .shaped (stg_shp[k])
      );
   end

   fracn_mod_sel #(
      .NW      (NW),
      .FW      (FW),
      .OFW     (OFW),
      .N_MIN   (N_MIN),
      .N_MAX   (N_MAX),
      .N_RESET (N_RESET)
   ) u_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_load    (cfg_load),
      .cfg_int     (cfg_int),
      .cfg_n       (cfg_n),
      .cfg_frac    (cfg_frac),
      .step        (div_pulse),
      .offset      (stg_shp[0]),
      .sh_frac     (sh_frac),
      .sh_int      (sh_int),
      .mod_value   (mod_value),
      .mod_offset  (mod_offset),
      .mod_valid   (mod_valid),
      .n_range_err (n_range_err)
   );

   fracn_cnt_div #(
      .NW (NW)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .modulus (mod_value),
      .pulse   (div_pulse)
   );

endmodule

// File: rtl/fracn_divseq_chk.sv
module fracn_divseq_chk
   import fracn_pkg::*;
#(
   parameter int NW    = 8,
   parameter int ORDER = 3,
   parameter int N_MIN = 35,
   parameter int N_MAX = 251
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_load,
   input logic [NW-1:0]         cfg_n,
   input logic [NW-1:0]         mod_value,
   input logic signed [ORDER:0] mod_offset,
   input logic                  mod_valid,
   input logic                  n_range_err,
   input logic                  div_pulse
);

   localparam int OFF_LO = fracn_off_min(ORDER);
   localparam int OFF_HI = fracn_off_max(ORDER);

   // R5
   mod_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(mod_value) >= N_MIN) && (int'(mod_value) <= N_MAX));

   // R3
   offset_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_valid |-> ((int'(mod_offset) >= OFF_LO) && (int'(mod_offset) <= OFF_HI)));

   // R7
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !div_pulse |=> ($stable(mod_value) && $stable(mod_offset)));

   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   // R9
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> mod_valid);

   // R9
   valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_valid |=> mod_valid);

   // R6
   range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (n_range_err == ((int'($past(cfg_n)) < N_MIN) || (int'($past(cfg_n)) > N_MAX))));

   // R6
   range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(n_range_err));

endmodule

bind fracn_divseq fracn_divseq_chk #(
   .NW    (NW),
   .ORDER (ORDER),
   .N_MIN (N_MIN),
   .N_MAX (N_MAX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_load    (cfg_load),
   .cfg_n       (cfg_n),
   .mod_value   (mod_value),
   .mod_offset  (mod_offset),
   .mod_valid   (mod_valid),
   .n_range_err (n_range_err),
   .div_pulse   (div_pulse)
);

// File: tb/test_fracn_divseq.sv
module test_fracn_divseq;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_load;
   logic              cfg_int;
   logic [7:0]        cfg_n;
   logic [27:0]       cfg_frac;
   logic [7:0]        mod_value;
   logic signed [3:0] mod_offset;
   logic              mod_valid;
   logic              n_range_err;
   logic              div_pulse;

   always #4 clk = ~clk;

   fracn_divseq i_fracn_divseq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_load    (cfg_load),
      .cfg_int     (cfg_int),
      .cfg_n       (cfg_n),
      .cfg_frac    (cfg_frac),
      .mod_value   (mod_value),
      .mod_offset  (mod_offset),
      .mod_valid   (mod_valid),
      .n_range_err (n_range_err),
      .div_pulse   (div_pulse)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;
   bit have_prev = 1'b0;
   int gap = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // R8: every division lasts exactly the modulus shown at its closing pulse
   always @(negedge clk) begin
      if (mon_on) begin
         gap++;
         if (div_pulse) begin
            if (have_prev) check(gap == int'(mod_value), "R8 division length", gap, mod_value);
            have_prev = 1'b1;
            gap = 0;
         end
      end
   end

   task automatic wait_pulse();
      do @(negedge clk); while (!div_pulse);
   endtask

   task automatic load_cfg(input int n, input longint f, input bit im);
      @(negedge clk);
      cfg_n    = 8'(n);
      cfg_frac = 28'(f);
      cfg_int  = im;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   function automatic longint expect_sum(input int n, input longint f, input int k);
      return longint'(k) * n + ((longint'(k) * f) >>> 28);
   endfunction

   // R2 and R3 over k divisions of one setting
   task automatic run_avg(input int n, input longint f, input int k);
      longint sum;
      longint want;
      load_cfg(n, f, 1'b0);
      wait_pulse();
      sum = 0;
      for (int i = 0; i < k; i++) begin
         wait_pulse();
         sum += mod_value;
         check((int'(mod_offset) >= -3) && (int'(mod_offset) <= 4), "R3 offset span", mod_offset, 0);
         check(int'(mod_value) == n + int'(mod_offset), "R3 modulus is N+offset", mod_value, n + int'(mod_offset));
      end
      want = expect_sum(n, f, k);
      check((sum - want >= -4) && (sum - want <= 4), "R2 long-run modulus sum", sum, want);
   endtask

   // R5: dithering against a bound is clipped to it
   task automatic run_clamp(input int n, input longint f, input int k);
      load_cfg(n, f, 1'b0);
      wait_pulse();
      for (int i = 0; i < k; i++) begin
         wait_pulse();
         check((mod_value >= 8'd35) && (mod_value <= 8'd251), "R5 modulus inside bounds", mod_value, n);
         if (int'(mod_offset) < 0 && n == 35) check(mod_value == 8'd35, "R5 low clip", mod_value, 35);
         if (int'(mod_offset) > 0 && n == 251) check(mod_value == 8'd251, "R5 high clip", mod_value, 251);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n    = 1'b0;
      cfg_load = 1'b0;
      cfg_int  = 1'b0;
      cfg_n    = '0;
      cfg_frac = '0;
      repeat (4) @(negedge clk);
      rst_n  = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(mod_valid == 1'b0, "R1 valid after reset", mod_valid, 0);
      check(mod_value == 8'd177, "R1 modulus after reset", mod_value, 177);
      check(mod_offset == 4'sd0, "R1 offset after reset", mod_offset, 0);
      check(n_range_err == 1'b0, "R1 range flag after reset", n_range_err, 0);

      // R9 valid rises at the first boundary
      wait_pulse();
      check(mod_valid == 1'b0, "R9 valid low before boundary", mod_valid, 0);
      @(negedge clk);
      check(mod_valid == 1'b1, "R9 valid after boundary", mod_valid, 1);
      check(mod_value == 8'd177, "R1 cleared accumulators give no dither", mod_value, 177);

      // R7 load mid-division: old length kept until the boundary
      repeat (5) @(negedge clk);
      load_cfg(40, 28'h9ABCDEF, 1'b1);
      while (!div_pulse) begin
         check(mod_value == 8'd177, "R7 modulus held mid-division", mod_value, 177);
         @(negedge clk);
      end
      check(mod_value == 8'd177, "R7 modulus at boundary", mod_value, 177);
      @(negedge clk);
      check(mod_value == 8'd40, "R7 new modulus after boundary", mod_value, 40);

      // R4 integer mode ignores F
      for (int i = 0; i < 20; i++) begin
         wait_pulse();
         check(mod_value == 8'd40, "R4 integer-mode modulus", mod_value, 40);
         check(mod_offset == 4'sd0, "R4 integer-mode offset", mod_offset, 0);
      end

      // R6 range flag and clipping of N
      load_cfg(20, 0, 1'b1);
      check(n_range_err == 1'b1, "R6 flag for low N", n_range_err, 1);
      wait_pulse(); wait_pulse();
      check(mod_value == 8'd35, "R6 low N used as lower bound", mod_value, 35);
      load_cfg(252, 0, 1'b1);
      check(n_range_err == 1'b1, "R6 flag for high N", n_range_err, 1);
      wait_pulse(); wait_pulse();
      check(mod_value == 8'd251, "R6 high N used as upper bound", mod_value, 251);
      load_cfg(35, 0, 1'b1);
      check(n_range_err == 1'b0, "R6 N=35 is legal", n_range_err, 0);
      load_cfg(251, 0, 1'b1);
      check(n_range_err == 1'b0, "R6 N=251 is legal", n_range_err, 0);
      load_cfg(100, 0, 1'b1);
      check(n_range_err == 1'b0, "R6 flag cleared by legal N", n_range_err, 0);
      wait_pulse(); wait_pulse();
      check(mod_value == 8'd100, "R6 legal N used as is", mod_value, 100);

      // R2 directed example ratio 86.05625
      run_avg(86, 15099494, 300);
      // R2 fraction near zero and near one
      run_avg(41, 1, 200);
      run_avg(45, 28'hFFFFFFF, 200);
      // R2 random settings
      for (int t = 0; t < 3; t++) begin
         int  rn;
         longint rf;
         rn = 39 + int'($urandom % 32);
         rf = longint'($urandom & 32'h0FFFFFFF);
         run_avg(rn, rf, 300);
      end

      // R5 clipping at both ends
      run_clamp(35, 28'h8000000, 200);
      run_clamp(251, 28'hFFFFFFF, 40);

      finish_run();
   end

endmodule